// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data Cache Lookup

This block is the lookup stage of a direct-mapped primary data cache. The line is chosen from bits of the untranslated program address. That lets the tag and data arrays start their read while a separate translation unit is still producing the physical frame number. In the same cycle, the frame number delivered with the request is compared against the physical tag stored in the selected line. The registered result then reports a hit, a miss or a translation fault, and on a hit it also returns the addressed 32-bit word.

The tag holds physical address bits only and carries no address-space identifier. A line therefore stays meaningful across a change of address space, and no flush is needed. The hardware does not detect aliases. Two program addresses that map to one physical location may select different lines, and keeping them apart is left to system software. A plain fill port writes a whole line, its physical tag and its valid bit. Refill sequencing and replacement are handled outside the block.

With the default parameters the block models 4 KB pages, an 8 KB cache and 16-byte lines. The index is taken from program address bits [12:4] and the tag is physical address bits [31:12].

Top module: `vipt_lookup`

## Requirements
- R1: After reset every line is invalid, so every translated lookup reports a miss until that line has been filled.
- R2: The line is selected by req_vaddr[12:4] only. Changing req_vaddr[31:13] with the same index and the same frame number gives the same outcome.
- R3: With req_valid and xlat_valid high, hit is 1 when the selected line is valid and its stored tag equals xlat_ppn. Otherwise miss is 1.
- R4: With req_valid high and xlat_valid low, xlat_fault is 1 and both hit and miss are 0.
- R5: On a hit, rd_data is word req_vaddr[3:2] of the line, where word k occupies line bits [32k+31:32k]. In every other case rd_data is 0.
- R6: A fill writes fill_data, fill_ptag and a set valid bit into line fill_vaddr[12:4] at the clock edge. A lookup presented in the same cycle sees the contents from before that write, and later lookups see the new contents.
- R7: Results are registered and appear on the outputs one clock after the request. In a cycle without req_valid, the next cycle's hit, miss, xlat_fault and rd_data are all 0.
- R8: A fill at one index leaves every other index unchanged, including an address that differs only in bit 12 and maps to the same frame.
- R9: At most one of hit, miss and xlat_fault is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all valid bits and the outputs |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_vaddr | input | 32 | Program address of the lookup |
| xlat_valid | input | 1 | Translation succeeded for this request |
| xlat_ppn | input | 20 | Physical frame number from the translation unit |
| fill_en | input | 1 | Write a line this cycle |
| fill_vaddr | input | 32 | Program address selecting the line to fill |
| fill_ptag | input | 20 | Physical tag stored with the filled line |
| fill_data | input | 128 | Line contents, word 0 in the low bits |
| hit | output | 1 | Registered hit result |
| miss | output | 1 | Registered miss result |
| rd_data | output | 32 | Registered word on a hit, otherwise 0 |
| xlat_fault | output | 1 | Registered fault for a request without valid translation |

## Verification
The assertions assume that reset is asserted before the first lookup. They also assume that the request, translation and fill inputs are stable and free of unknowns around each rising clock edge. The frame number may be any value when xlat_valid is low. The stimulus is driven only at falling edges, which keeps it inside these limits. Random cycles draw indexes and frame numbers from small pools so that hits, tag mismatches, faults, alias-bit lookups and fills colliding with lookups at the same index all occur often.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int unsigned VA_W        = 32;
    localparam int unsigned PA_W        = 32;
    localparam int unsigned PAGE_BYTES  = 4096;
    localparam int unsigned LINE_BYTES  = 16;
    localparam int unsigned CACHE_BYTES = 8192;
    localparam int unsigned WORD_W      = 32;

    localparam int unsigned OFF_W   = $clog2(LINE_BYTES);
    localparam int unsigned PGOFF_W = $clog2(PAGE_BYTES);
    localparam int unsigned SETS    = CACHE_BYTES / LINE_BYTES;
    localparam int unsigned IDX_W   = $clog2(SETS);
    localparam int unsigned TAG_W   = PA_W - PGOFF_W;
    localparam int unsigned LINE_W  = LINE_BYTES * 8;
    localparam int unsigned WORDS   = LINE_W / WORD_W;
    localparam int unsigned WSEL_W  = $clog2(WORDS);
    localparam int unsigned WOFF_W  = $clog2(WORD_W / 8);

    typedef struct packed {
        logic              hit;
        logic              miss;
        logic              fault;
        logic [WORD_W-1:0] data;
    } lookup_res_t;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int unsigned SETS  = 512,
    parameter int unsigned IDX_W = 9,
    parameter int unsigned TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [SETS-1:0]  valid_d, valid_q;
    logic [TAG_W-1:0] tag_mem [SETS];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_idx] <= wr_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];

    // R6: a filled line reads back as valid in the next cycle
    a_r6_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);
    // R1: valid bits only ever get set by a fill
    a_r1_valid_only_by_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (valid_q == $past(valid_q)));
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
    parameter int unsigned SETS   = 512,
    parameter int unsigned IDX_W  = 9,
    parameter int unsigned LINE_W = 128
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINE_W-1:0] line_mem [SETS];

    always_ff @(posedge clk) begin
        if (wr_en) line_mem[wr_idx] <= wr_line;
    end

    assign rd_line = line_mem[rd_idx];
endmodule

// File: rtl/vipt_compare.sv
module vipt_compare
    import vipt_pkg::*;
#(
    parameter int unsigned TAG_W_P  = TAG_W,
    parameter int unsigned LINE_W_P = LINE_W,
    parameter int unsigned WORD_W_P = WORD_W,
    parameter int unsigned WORDS_P  = LINE_W_P / WORD_W_P,
    parameter int unsigned WSEL_W_P = $clog2(WORDS_P)
) (
    input  logic                req_valid,
    input  logic                xlat_valid,
    input  logic [TAG_W_P-1:0]  xlat_ppn,
    input  logic                line_valid,
    input  logic [TAG_W_P-1:0]  line_tag,
    input  logic [LINE_W_P-1:0] line_data,
    input  logic [WSEL_W_P-1:0] word_sel,
    output lookup_res_t         res
);
    logic [WORD_W_P-1:0] words [WORDS_P];
    logic                tag_match;

    for (genvar g = 0; g < WORDS_P; g++) begin : g_word
        assign words[g] = line_data[g*WORD_W_P +: WORD_W_P];
    end

    assign tag_match = line_valid && (line_tag == xlat_ppn);

    always_comb begin
        res.hit   = req_valid && xlat_valid && tag_match;
        res.miss  = req_valid && xlat_valid && !tag_match;
        res.fault = req_valid && !xlat_valid;
        res.data  = res.hit ? words[word_sel] : '0;
    end
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              xlat_valid,
    input  logic [TAG_W-1:0]  xlat_ppn,
    input  logic              fill_en,
    input  logic [VA_W-1:0]   fill_vaddr,
    input  logic [TAG_W-1:0]  fill_ptag,
    input  logic [LINE_W-1:0] fill_data,
    output logic              hit,
    output logic              miss,
    output logic [WORD_W-1:0] rd_data,
    output logic              xlat_fault
);
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [WSEL_W-1:0] word_sel;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [LINE_W-1:0] line_data;
    lookup_res_t       res_d, res_q, cmp_res;
    logic              unused_addr_bits;

    assign rd_idx   = req_vaddr[OFF_W +: IDX_W];
    assign wr_idx   = fill_vaddr[OFF_W +: IDX_W];
    assign word_sel = req_vaddr[WOFF_W +: WSEL_W];
    assign unused_addr_bits = ^{req_vaddr[VA_W-1:OFF_W+IDX_W], req_vaddr[WOFF_W-1:0],
                                fill_vaddr[VA_W-1:OFF_W+IDX_W], fill_vaddr[OFF_W-1:0]};

    vipt_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_valid(line_valid), .rd_tag(line_tag),
        .wr_en(fill_en), .wr_idx(wr_idx), .wr_tag(fill_ptag)
    );

    vipt_data_store #(.SETS(SETS), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_data (
        .clk(clk),
        .rd_idx(rd_idx), .rd_line(line_data),
        .wr_en(fill_en), .wr_idx(wr_idx), .wr_line(fill_data)
    );

    vipt_compare u_cmp (
        .req_valid(req_valid), .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn),
        .line_valid(line_valid), .line_tag(line_tag), .line_data(line_data),
        .word_sel(word_sel), .res(cmp_res)
    );

    always_comb begin
        res_d = cmp_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign hit        = res_q.hit;
    assign miss       = res_q.miss;
    assign xlat_fault = res_q.fault;
    assign rd_data    = res_q.data;

    // R9: outcomes are exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit, miss, xlat_fault}));
    // R4: untranslated request faults and never hits
    a_r4_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlat_valid) |=> (xlat_fault && !hit && !miss));
    // R3: a translated request always resolves to hit or miss
    a_r3_resolves: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlat_valid) |=> (hit || miss));
    // R7: idle cycle gives quiet outputs
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!hit && !miss && !xlat_fault && rd_data == '0));
    // R5: data is zero whenever there is no hit
    a_r5_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (rd_data == '0));
endmodule

// File: tb/tb_vipt_lookup.sv
module tb_vipt_lookup;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, xlat_valid, fill_en;
    logic [31:0]  req_vaddr, fill_vaddr;
    logic [19:0]  xlat_ppn, fill_ptag;
    logic [127:0] fill_data;
    logic         hit, miss, xlat_fault;
    logic [31:0]  rd_data;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    bit           ref_v [512];
    logic [19:0]  ref_t [512];
    logic [127:0] ref_d [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    vipt_lookup dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn), .fill_en(fill_en),
        .fill_vaddr(fill_vaddr), .fill_ptag(fill_ptag), .fill_data(fill_data),
        .hit(hit), .miss(miss), .rd_data(rd_data), .xlat_fault(xlat_fault)
    );

    function automatic logic [31:0] exp_word(input logic [127:0] line, input logic [1:0] sel);
        return line[sel*32 +: 32];
    endfunction

    task automatic check(input string req, input logic eh, input logic em, input logic ef,
                         input logic [31:0] ed);
        tests++;
        if (hit !== eh || miss !== em || xlat_fault !== ef || rd_data !== ed) begin
            fails++;
            $display("FAIL %s: got hit=%0b miss=%0b fault=%0b data=%h, expected hit=%0b miss=%0b fault=%0b data=%h",
                     req, hit, miss, xlat_fault, rd_data, eh, em, ef, ed);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, compare at the next falling edge.
    task automatic step(input string req, input logic rq, input logic [31:0] va,
                        input logic xv, input logic [19:0] ppn,
                        input logic fe, input logic [31:0] fva,
                        input logic [19:0] ft, input logic [127:0] fd);
        logic [8:0]  idx;
        logic        eh, em, ef;
        logic [31:0] ed;
        req_valid = rq; req_vaddr = va; xlat_valid = xv; xlat_ppn = ppn;
        fill_en = fe; fill_vaddr = fva; fill_ptag = ft; fill_data = fd;
        idx = va[12:4];
        ef  = rq && !xv;
        eh  = rq && xv && ref_v[idx] && (ref_t[idx] == ppn);
        em  = rq && xv && !eh;
        ed  = eh ? exp_word(ref_d[idx], va[3:2]) : 32'h0;
        @(posedge clk);
        if (fe) begin
            ref_v[fva[12:4]] = 1'b1;
            ref_t[fva[12:4]] = ft;
            ref_d[fva[12:4]] = fd;
        end
        @(negedge clk);
        check(req, eh, em, ef, ed);
    endtask

    task automatic look(input string req, input logic [31:0] va, input logic xv, input logic [19:0] ppn);
        step(req, 1'b1, va, xv, ppn, 1'b0, 32'h0, 20'h0, 128'h0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [127:0] line_a;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 512; i++) ref_v[i] = 1'b0;
        rst_n = 1'b0;
        req_valid = 0; xlat_valid = 0; fill_en = 0;
        req_vaddr = 0; fill_vaddr = 0; xlat_ppn = 0; fill_ptag = 0; fill_data = 0;
        repeat (3) @(negedge clk);
        check("R7 reset outputs", 1'b0, 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: nothing valid after reset
        look("R1 empty idx0", 32'h0000_0000, 1'b1, 20'h00000);
        look("R1 empty idx5", 32'h0000_0050, 1'b1, 20'h00000);
        look("R1 empty idx511", 32'h0000_1FF0, 1'b1, 20'h00000);

        // R6: fill with same-cycle lookup sees the old line
        line_a = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
        step("R6 same-cycle old contents", 1'b1, 32'h0000_0030, 1'b1, 20'hABCDE,
             1'b1, 32'h0000_0030, 20'hABCDE, line_a);
        // R5: every word of the line
        for (int w = 0; w < 4; w++)
            look("R5 word select", 32'h0000_0030 | (w << 2), 1'b1, 20'hABCDE);
        // R2: upper program-address bits ignored
        look("R2 upper bits differ", 32'hFFFF_E034, 1'b1, 20'hABCDE);
        // R8: alias in bit 12 selects another line
        look("R8 bit12 alias", 32'h0000_1030, 1'b1, 20'hABCDE);
        // R3: frame mismatch
        look("R3 tag mismatch", 32'h0000_0030, 1'b1, 20'hABCDF);
        // R4: translation fault
        look("R4 fault", 32'h0000_0030, 1'b0, 20'hABCDE);
        // R7: idle request
        step("R7 idle", 1'b0, 32'h0000_0030, 1'b1, 20'hABCDE, 1'b0, 32'h0, 20'h0, 128'h0);
        // R6: refill replaces tag
        step("R6 refill", 1'b0, 32'h0, 1'b0, 20'h0, 1'b1, 32'h0000_0038, 20'h12345,
             128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_1234_5678);
        look("R6 old tag gone", 32'h0000_0030, 1'b1, 20'hABCDE);
        look("R6 new tag hits", 32'h0000_003C, 1'b1, 20'h12345);
        look("R8 neighbour untouched", 32'h0000_1030, 1'b1, 20'h12345);

        // Random mix, R3/R4/R5/R6/R8/R9
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] va, fva;
            logic rq, xv, fe;
            logic [19:0] ppn, ft;
            va  = {$urandom_range(3, 0) << 13} | ($urandom_range(1, 0) << 12)
                | ($urandom_range(7, 0) << 4) | ($urandom_range(3, 0) << 2);
            fva = ($urandom_range(1, 0) << 12) | ($urandom_range(7, 0) << 4);
            rq  = ($urandom_range(9, 0) != 0);
            xv  = ($urandom_range(7, 0) != 0);
            fe  = ($urandom_range(4, 0) == 0);
            ppn = 20'(32'h100 + $urandom_range(3, 0));
            ft  = 20'(32'h100 + $urandom_range(3, 0));
            step("R3 random lookup", rq, va, xv, ppn, fe, fva, ft,
                 {$urandom, $urandom, $urandom, $urandom});
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule